// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This unit sits beside the decode stage of an in-order pipeline that has a forwarding network. Forwarding can hand an ALU result to the next instruction, but a value read from data memory is produced one stage too late for an instruction that needs it as an ALU operand right behind the load. The unit compares the source registers of the instruction being decoded with the destination of the instruction now in execute. When that instruction is a valid load, and a source that will be read early matches its nonzero destination, the unit freezes the front of the pipeline for one cycle.

During a freeze the program counter and the fetch/decode instruction register keep their contents, so the same instruction is fetched and decoded again on the next cycle. A no-operation is injected into the decode/execute register in its place, and the stages behind it carry on. On the retry the load has moved on to the memory stage, and forwarding supplies the value. The unit is combinational and holds nothing between cycles. Each freeze therefore ends on its own once the load has left execute.

A source that is consumed only in the memory stage, such as the data of a store, is flagged by the decoder. It never causes a freeze, because the memory stage can take the loaded value there.

Top module: `load_use_interlock`

## Requirements
- R1: When `ex_valid`=1, `ex_mem_read`=1, `ex_dst`≠0 and `id_rs_used`=1 with `id_rs`=`ex_dst`, the unit drives `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1 in that same cycle.
- R2: When `ex_valid`=1, `ex_mem_read`=1, `ex_dst`≠0, `id_rt_used`=1, `id_rt_mem_only`=0 and `id_rt`=`ex_dst`, the unit freezes the front and sends a bubble, exactly as in R1. This also holds when both sources match.
- R3: With no hazard, the unit drives `pc_we`=1, `ifid_we`=1 and `idex_bubble`=0. This includes a load whose destination matches neither used source.
- R4: A matching instruction in execute with `ex_valid`=0 causes no freeze.
- R5: A matching instruction in execute with `ex_mem_read`=0 (an ALU result, which can be forwarded) causes no freeze.
- R6: A load with `ex_dst`=0 (the hard-wired zero register) causes no freeze, even when a used source is also 0.
- R7: A source whose use flag is 0 causes no freeze, even when its index equals the load destination.
- R8: With `id_rt_mem_only`=1 (rt is store data), a match on rt alone causes no freeze. A match on rs still freezes the front.
- R9: The unit keeps no state. In a running pipeline, a load followed directly by a dependent instruction yields exactly one freeze cycle. The dependent instruction is decoded in two consecutive cycles, and it enters execute two cycles after the load.
- R10: `pc_we` and `ifid_we` are always equal, and `idex_bubble` is always their inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_AW | First source register index of the decoding instruction |
| id_rt | input | REG_AW | Second source register index of the decoding instruction |
| id_rs_used | input | 1 | Decoding instruction reads its first source |
| id_rt_used | input | 1 | Decoding instruction reads its second source |
| id_rt_mem_only | input | 1 | Second source is needed only in the memory stage (store data) |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_mem_read | input | 1 | Execute-stage instruction reads data memory (load) |
| ex_dst | input | REG_AW | Destination register index of the execute-stage instruction |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode instruction register update enable |
| idex_bubble | output | 1 | Replace the decode/execute register contents with a no-operation |

## Verification
The hardest case to reach from the ports is the one-cycle length of a freeze. The unit only sees the present inputs, so a single freeze can be told apart from a stuck one only when the execute stage really changes after it. The bench therefore builds a small fetch/decode/execute model around the unit. The model honours the enables and the bubble, then runs a load followed by a dependent instruction and an unrelated one. It checks which cycles froze, that the dependent instruction was decoded twice, and when that instruction reached execute.

// File: rtl/load_use_pkg.sv
`timescale 1ns/1ps
package load_use_pkg;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic idex_bubble;
    } front_ctrl_t;

    localparam front_ctrl_t FRONT_RUN    = '{pc_we: 1'b1, ifid_we: 1'b1, idex_bubble: 1'b0};
    localparam front_ctrl_t FRONT_FREEZE = '{pc_we: 1'b0, ifid_we: 1'b0, idex_bubble: 1'b1};

endpackage

// File: rtl/lu_src_match.sv
`timescale 1ns/1ps
module lu_src_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_idx,
    input  logic              src_used,
    input  logic              src_late,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_dst,
    output logic              hit
);
    logic dst_live;
    logic early_need;

    always_comb begin
        dst_live   = ex_is_load && (ex_dst != '0);
        early_need = src_used && !src_late;
        hit        = dst_live && early_need && (src_idx == ex_dst);
    end

endmodule

// File: rtl/lu_front_ctrl.sv
`timescale 1ns/1ps
module lu_front_ctrl
    import load_use_pkg::*;
(
    input  logic        freeze,
    output front_ctrl_t ctrl
);
    always_comb begin
        ctrl = freeze ? FRONT_FREEZE : FRONT_RUN;
    end

endmodule

// File: rtl/load_use_interlock.sv
`timescale 1ns/1ps
module load_use_interlock
    import load_use_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              id_rs_used,
    input  logic              id_rt_used,
    input  logic              id_rt_mem_only,
    input  logic              ex_valid,
    input  logic              ex_mem_read,
    input  logic [REG_AW-1:0] ex_dst,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              idex_bubble
);
    localparam int NUM_SRC = 2;

    logic [REG_AW-1:0] src_idx  [NUM_SRC];
    logic              src_used [NUM_SRC];
    logic              src_late [NUM_SRC];
    logic [NUM_SRC-1:0] src_hit;
    logic              ex_is_load;
    logic              freeze_d;
    front_ctrl_t       ctrl_d;

    always_comb begin
        src_idx[0]  = id_rs;
        src_used[0] = id_rs_used;
        src_late[0] = 1'b0;
        src_idx[1]  = id_rt;
        src_used[1] = id_rt_used;
        src_late[1] = id_rt_mem_only;
        ex_is_load  = ex_valid && ex_mem_read;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        lu_src_match #(.REG_AW(REG_AW)) u_match (
            .src_idx    (src_idx[g]),
            .src_used   (src_used[g]),
            .src_late   (src_late[g]),
            .ex_is_load (ex_is_load),
            .ex_dst     (ex_dst),
            .hit        (src_hit[g])
        );
    end

    always_comb begin
        freeze_d = |src_hit;
    end

    lu_front_ctrl u_front (
        .freeze (freeze_d),
        .ctrl   (ctrl_d)
    );

    always_comb begin
        pc_we       = ctrl_d.pc_we;
        ifid_we     = ctrl_d.ifid_we;
        idex_bubble = ctrl_d.idex_bubble;
    end

endmodule

// File: rtl/load_use_interlock_chk.sv
`timescale 1ns/1ps
module load_use_interlock_chk #(
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] id_rs,
    input logic [REG_AW-1:0] id_rt,
    input logic              id_rs_used,
    input logic              id_rt_used,
    input logic              id_rt_mem_only,
    input logic              ex_valid,
    input logic              ex_mem_read,
    input logic [REG_AW-1:0] ex_dst,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              idex_bubble
);
    logic rs_needs;
    logic rt_needs;

    always_comb begin
        rs_needs = id_rs_used && (id_rs == ex_dst);
        rt_needs = id_rt_used && !id_rt_mem_only && (id_rt == ex_dst);
        AST_ENABLES_MATCH: assert (pc_we == ifid_we) else $error("enables differ"); // R10
        AST_BUBBLE_EXCLUSIVE: assert (idex_bubble != pc_we) else $error("bubble with running front"); // R10
        AST_FREEZE_NEEDS_LOAD: assert (!idex_bubble || (ex_valid && ex_mem_read)) else $error("freeze without valid load"); // R4
        AST_FREEZE_NONZERO_DST: assert (!idex_bubble || (ex_dst != '0)) else $error("freeze on zero register"); // R6
        AST_FREEZE_NEEDS_USE: assert (!idex_bubble || rs_needs || rt_needs) else $error("freeze without early source match"); // R8
        AST_LOAD_USE_FREEZES: assert (!(ex_valid && ex_mem_read && ex_dst != '0 && (rs_needs || rt_needs)) || idex_bubble) else $error("missed load-use hazard"); // R1
    end

endmodule

bind load_use_interlock load_use_interlock_chk #(.REG_AW(REG_AW)) u_chk (
    .id_rs          (id_rs),
    .id_rt          (id_rt),
    .id_rs_used     (id_rs_used),
    .id_rt_used     (id_rt_used),
    .id_rt_mem_only (id_rt_mem_only),
    .ex_valid       (ex_valid),
    .ex_mem_read    (ex_mem_read),
    .ex_dst         (ex_dst),
    .pc_we          (pc_we),
    .ifid_we        (ifid_we),
    .idex_bubble    (idex_bubble)
);

// File: tb/load_use_interlock_tb.sv
`timescale 1ns/1ps
module load_use_interlock_tb;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] id_rs = '0, id_rt = '0, ex_dst = '0;
    logic id_rs_used = 1'b0, id_rt_used = 1'b0, id_rt_mem_only = 1'b0;
    logic ex_valid = 1'b0, ex_mem_read = 1'b0;
    logic pc_we, ifid_we, idex_bubble;

    int n_checks = 0;
    int n_errors = 0;

    load_use_interlock #(.REG_AW(AW)) u_dut (
        .id_rs (id_rs), .id_rt (id_rt),
        .id_rs_used (id_rs_used), .id_rt_used (id_rt_used),
        .id_rt_mem_only (id_rt_mem_only),
        .ex_valid (ex_valid), .ex_mem_read (ex_mem_read), .ex_dst (ex_dst),
        .pc_we (pc_we), .ifid_we (ifid_we), .idex_bubble (idex_bubble)
    );

    typedef struct packed {
        logic          valid;
        logic          load;
        logic [AW-1:0] dst;
        logic [AW-1:0] rs;
        logic [AW-1:0] rt;
        logic          rs_u;
        logic          rt_u;
        logic          rt_late;
        logic [7:0]    tag;
    } instr_t;

    localparam instr_t NOP = '0;

    task automatic check_front(input string req, input logic exp_freeze);
        n_checks++;
        if ({pc_we, ifid_we, idex_bubble} !== {~exp_freeze, ~exp_freeze, exp_freeze}) begin
            n_errors++;
            $display("FAIL %s: pc_we/ifid_we/bubble=%b%b%b expected %b%b%b", req,
                     pc_we, ifid_we, idex_bubble, ~exp_freeze, ~exp_freeze, exp_freeze);
        end
    endtask

    task automatic drive(input logic [AW-1:0] rs, input logic rsu, input logic [AW-1:0] rt,
                         input logic rtu, input logic late, input logic v, input logic mr,
                         input logic [AW-1:0] dst);
        @(negedge clk);
        id_rs = rs; id_rs_used = rsu; id_rt = rt; id_rt_used = rtu; id_rt_mem_only = late;
        ex_valid = v; ex_mem_read = mr; ex_dst = dst;
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_front("R3 reset", 1'b0);
    endtask

    task automatic t_rs_hit;
        drive(5'd7, 1, 5'd2, 1, 0, 1, 1, 5'd7);
        check_front("R1 rs match", 1'b1);
        drive(5'd31, 1, 5'd0, 0, 0, 1, 1, 5'd31);
        check_front("R1 rs match r31", 1'b1);
    endtask

    task automatic t_rt_hit;
        drive(5'd4, 1, 5'd9, 1, 0, 1, 1, 5'd9);
        check_front("R2 rt match", 1'b1);
        drive(5'd9, 1, 5'd9, 1, 0, 1, 1, 5'd9);
        check_front("R2 both match", 1'b1);
    endtask

    task automatic t_no_hazard;
        drive(5'd3, 1, 5'd4, 1, 0, 1, 1, 5'd5);
        check_front("R3 load unrelated", 1'b0);
        drive(5'd15, 1, 5'd14, 1, 0, 1, 1, 5'd31);
        check_front("R3 near miss", 1'b0);
    endtask

    task automatic t_invalid;
        drive(5'd6, 1, 5'd6, 1, 0, 0, 1, 5'd6);
        check_front("R4 invalid ex", 1'b0);
    endtask

    task automatic t_alu;
        drive(5'd6, 1, 5'd6, 1, 0, 1, 0, 5'd6);
        check_front("R5 alu producer", 1'b0);
    endtask

    task automatic t_zero;
        drive(5'd0, 1, 5'd0, 1, 0, 1, 1, 5'd0);
        check_front("R6 zero dst", 1'b0);
    endtask

    task automatic t_unused;
        drive(5'd8, 0, 5'd8, 0, 0, 1, 1, 5'd8);
        check_front("R7 unused sources", 1'b0);
        drive(5'd8, 0, 5'd1, 1, 0, 1, 1, 5'd8);
        check_front("R7 rs unused", 1'b0);
    endtask

    task automatic t_store;
        drive(5'd2, 1, 5'd10, 1, 1, 1, 1, 5'd10);
        check_front("R8 store data only", 1'b0);
        drive(5'd10, 1, 5'd3, 1, 1, 1, 1, 5'd10);
        check_front("R8 store address", 1'b1);
    endtask

    task automatic t_pipeline;
        instr_t prog [4];
        instr_t ifid, ex;
        int pc;
        int freezes;
        logic freeze_seen [6];
        int dep_dec;
        logic [7:0] ex_at3;
        prog[0] = '{valid:1, load:1, dst:5'd3, rs:5'd1, rt:5'd0, rs_u:1, rt_u:0, rt_late:0, tag:8'd1};
        prog[1] = '{valid:1, load:0, dst:5'd4, rs:5'd3, rt:5'd2, rs_u:1, rt_u:1, rt_late:0, tag:8'd2};
        prog[2] = '{valid:1, load:0, dst:5'd5, rs:5'd6, rt:5'd7, rs_u:1, rt_u:1, rt_late:0, tag:8'd3};
        prog[3] = '{valid:1, load:0, dst:5'd8, rs:5'd6, rt:5'd7, rs_u:1, rt_u:1, rt_late:0, tag:8'd4};
        ifid = prog[0]; ex = NOP; pc = 1; freezes = 0; dep_dec = 0; ex_at3 = '0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            id_rs = ifid.rs; id_rt = ifid.rt; id_rs_used = ifid.rs_u; id_rt_used = ifid.rt_u;
            id_rt_mem_only = ifid.rt_late;
            ex_valid = ex.valid; ex_mem_read = ex.load; ex_dst = ex.dst;
            #1;
            if (c == 3) ex_at3 = ex.tag;
            if (ifid.tag == 8'd2) dep_dec++;
            freeze_seen[c] = idex_bubble;
            if (idex_bubble) freezes++;
            ex = idex_bubble ? NOP : ifid;
            if (ifid_we) ifid = (pc < 4) ? prog[pc] : NOP;
            if (pc_we) pc++;
        end
        n_checks++;
        if (freezes != 1) begin
            n_errors++;
            $display("FAIL R9 freeze count: %0d expected 1", freezes);
        end
        n_checks++;
        if (freeze_seen[1] !== 1'b1) begin
            n_errors++;
            $display("FAIL R9 freeze cycle: cycle1=%b expected 1", freeze_seen[1]);
        end
        n_checks++;
        if (dep_dec != 2) begin
            n_errors++;
            $display("FAIL R9 decode repeats: %0d expected 2", dep_dec);
        end
        n_checks++;
        if (ex_at3 != 8'd2) begin
            n_errors++;
            $display("FAIL R9 execute at cycle3: tag %0d expected 2", ex_at3);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                t_reset();
                rst_n = 1'b1;
                t_rs_hit();
                t_rt_hit();
                t_no_hazard();
                t_invalid();
                t_alu();
                t_zero();
                t_unused();
                t_store();
                t_pipeline();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule